// File: doc/BRIEF.md
# Parallel NOR Flash Word-Program Sequencer

This block takes one word-program request from a host on a synchronous clock and carries it out on an asynchronous parallel NOR flash. The host gives a one-cycle start pulse with a word address and a data word. The sequencer first writes the program command (data 0xA0 at address 0x555), then writes the host's data to the host's address. After that it waits for the flash's ready/busy pin to report that the operation has finished. Each write is controlled by write-enable. The sequencer drives chip-enable, output-enable, write-enable, the address bus, and a data bus with a separate drive-enable.

All strobe minima are parameters given in nanoseconds. They are converted to whole clock cycles by rounding up, and every phase is timed by one shared down-counter. After the last write, the ready/busy input is ignored for the flash's worst-case busy-assertion delay. The input is then synchronised and polled. A timeout counter stops a flash that hangs, and reports it as an error. Start pulses that arrive while the block is busy are dropped.

Top module: `nor_prog_seq`

## Requirements
- R1: After reset, chip-enable, write-enable and output-enable are high (inactive), the data bus is not driven, and busy, done and error are low.
- R2: A start accepted while idle raises busy and produces exactly two write-enable pulses. The first pulse carries address 0x555 and data 0xA0. The second carries the address and data that were presented with the start.
- R3: Each write-enable low pulse lasts exactly max(ceil(tWP/Tclk), ceil(tDS/Tclk)) cycles, which is 7 at the defaults. Address and data stay unchanged for as long as the data bus is driven.
- R4: Between the two pulses, write-enable stays high for at least ceil(tWPH/Tclk) cycles (4 at the defaults). Consecutive falling edges are at least ceil(tWC/Tclk) cycles apart (11 at the defaults).
- R5: Chip-enable is low and output-enable is high whenever write-enable is low.
- R6: The data bus is driven whenever write-enable is low. It is never driven, and chip-enable is high, while the block is not busy.
- R7: The ready/busy input is ignored for ceil(tBUSY/Tclk) cycles after the last write-enable rise (18 at the defaults). A flash that reports ready the whole time does not complete the operation sooner than that.
- R8: Once ready/busy (high = ready) is seen high after that window, done pulses for exactly one cycle. Busy is low in that cycle, and error is low. Completion follows the ready rise within a few cycles of synchronisation.
- R9: If ready/busy stays low for TIMEOUT_CYC polling cycles, done pulses with error high. Error stays high until the next accepted start.
- R10: A start while busy is ignored. The running operation keeps its address and data, and no further write cycles follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_i | input | 1 | One-cycle request to program one word |
| addr_i | input | ADDR_W | Program address, captured with start |
| data_i | input | DATA_W | Program data, captured with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error, held until the next start |
| flash_ce_n_o | output | 1 | Flash chip-enable, active low |
| flash_oe_n_o | output | 1 | Flash output-enable, active low |
| flash_we_n_o | output | 1 | Flash write-enable, active low |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_dq_o | output | DATA_W | Flash data bus value |
| flash_dq_oe_o | output | 1 | Data bus drive-enable |
| flash_rdy_i | input | 1 | Flash ready/busy pin, high = ready |

## Verification
The assertions check the following on every cycle:
- strobe relationships: chip-enable and bus drive during a low write-enable, and no drive while idle;
- address and data stability inside a pulse;
- exact pulse width and minimum high gap, using run counters;
- the single-cycle done pulse;
- no completion earlier than the busy-assertion window after the last rise.

Some behaviours can only be shown by the bench's scenarios:
- which address and data each of the two cycles carries;
- that a start during busy is dropped;
- the timeout path with the sticky error;
- the latency from the ready rise to done.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WLO,
    ST_WHI,
    ST_BWAIT,
    ST_POLL
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_phase_timer.sv
module nor_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nor_rdy_watch.sv
module nor_rdy_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 4000,
  localparam int TO_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_async_i,
  input  logic poll_i,
  output logic rdy_o,
  output logic expired_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TO_W-1:0]        to_q, to_d;
  logic                   to_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_async_i};
  end

  assign rdy_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    to_en = poll_i || (to_q != '0);
    to_d  = poll_i ? to_q + TO_W'(1) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    to_q <= '0;
    else if (to_en) to_q <= to_d;
  end

  assign expired_o = poll_i && (to_q == TO_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 32,
  parameter int CLK_NS      = 5,
  parameter int T_WP_NS     = 35,
  parameter int T_DS_NS     = 35,
  parameter int T_WPH_NS    = 20,
  parameter int T_AH_NS     = 45,
  parameter int T_WC_NS     = 55,
  parameter int T_BUSY_NS   = 90,
  parameter int TIMEOUT_CYC = 4000,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(12'h555),
  parameter logic [DATA_W-1:0] CMD_DATA = DATA_W'(8'hA0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              flash_ce_n_o,
  output logic              flash_oe_n_o,
  output logic              flash_we_n_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe_o,
  input  logic              flash_rdy_i
);

  localparam int WP_CYC   = imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int WPH_CYC  = ns2cyc(T_WPH_NS, CLK_NS);
  localparam int HI_CYC   = imax(imax(WPH_CYC, ns2cyc(T_WC_NS, CLK_NS) - WP_CYC - 1),
                                 imax(ns2cyc(T_AH_NS, CLK_NS) - WP_CYC, 1));
  localparam int BUSY_CYC = imax(ns2cyc(T_BUSY_NS, CLK_NS), 1);
  localparam int CNT_W    = $clog2(imax(imax(WP_CYC, HI_CYC), BUSY_CYC) + 1);

  seq_state_e        st_q, st_d;
  logic              second_q, second_d;
  logic [ADDR_W-1:0] pa_q;
  logic [DATA_W-1:0] pd_q;
  logic              cap_en;
  logic              done_q, done_d, err_q, err_d;
  logic              ce_n_q, ce_n_d, we_n_q, we_n_d, dq_oe_q, dq_oe_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [DATA_W-1:0] fd_q, fd_d;
  logic              tm_load, tm_zero;
  logic [CNT_W-1:0]  tm_val;
  logic              rdy_s, to_expired;
  logic              in_cycle;

  nor_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .zero_o     (tm_zero)
  );

  nor_rdy_watch #(
    .SYNC_STAGES (SYNC_STAGES),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_rdy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rdy_async_i (flash_rdy_i),
    .poll_i      (st_q == ST_POLL),
    .rdy_o       (rdy_s),
    .expired_o   (to_expired)
  );

  // next-state process
  always_comb begin
    st_d     = st_q;
    second_d = second_q;
    tm_load  = 1'b0;
    tm_val   = '0;
    done_d   = 1'b0;
    err_d    = err_q;
    cap_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_SETUP;
          second_d = 1'b0;
          err_d    = 1'b0;
          cap_en   = 1'b1;
          tm_load  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tm_zero) begin
          st_d    = ST_WLO;
          tm_load = 1'b1;
          tm_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WLO: begin
        if (tm_zero) begin
          st_d    = ST_WHI;
          tm_load = 1'b1;
          tm_val  = CNT_W'(HI_CYC - 1);
        end
      end
      ST_WHI: begin
        if (tm_zero) begin
          tm_load = 1'b1;
          if (!second_q) begin
            st_d     = ST_SETUP;
            second_d = 1'b1;
          end else begin
            st_d   = ST_BWAIT;
            tm_val = CNT_W'(BUSY_CYC - 1);
          end
        end
      end
      ST_BWAIT: begin
        if (tm_zero) st_d = ST_POLL;
      end
      ST_POLL: begin
        if (rdy_s) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else if (to_expired) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          err_d  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registered flash strobes, decoded from the next state
  always_comb begin
    in_cycle = (st_d == ST_SETUP) || (st_d == ST_WLO) || (st_d == ST_WHI);
    ce_n_d   = !in_cycle;
    we_n_d   = (st_d != ST_WLO);
    dq_oe_d  = (st_d == ST_WLO) || (st_d == ST_WHI);
    fa_d     = '0;
    fd_d     = '0;
    if (in_cycle) begin
      fa_d = second_d ? pa_q : CMD_ADDR;
      fd_d = second_d ? pd_q : CMD_DATA;
    end
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      ce_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      dq_oe_q  <= 1'b0;
      fa_q     <= '0;
      fd_q     <= '0;
    end else begin
      st_q     <= st_d;
      second_q <= second_d;
      done_q   <= done_d;
      err_q    <= err_d;
      ce_n_q   <= ce_n_d;
      we_n_q   <= we_n_d;
      dq_oe_q  <= dq_oe_d;
      fa_q     <= fa_d;
      fd_q     <= fd_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0;
      pd_q <= '0;
    end else if (cap_en) begin
      pa_q <= addr_i;
      pd_q <= data_i;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign flash_ce_n_o  = ce_n_q;
  assign flash_oe_n_o  = 1'b1;  // write-only sequencer: reads never enabled
  assign flash_we_n_o  = we_n_q;
  assign flash_addr_o  = fa_q;
  assign flash_dq_o    = fd_q;
  assign flash_dq_oe_o = dq_oe_q;

endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int WP_CYC   = 7,
  parameter int WPH_CYC  = 4,
  parameter int BUSY_CYC = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              flash_ce_n_o,
  input logic              flash_oe_n_o,
  input logic              flash_we_n_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [DATA_W-1:0] flash_dq_o,
  input logic              flash_dq_oe_o
);

  logic [15:0] lo_run, hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= '0;
      hi_run <= 16'hFFFF;
    end else if (!flash_we_n_o) begin
      lo_run <= lo_run + 16'd1;
      hi_run <= '0;
    end else begin
      lo_run <= '0;
      if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
    end
  end

  AST_PULSE_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_n_o && $past(!flash_we_n_o)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o))); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_n_o) |-> (lo_run == 16'(WP_CYC))); // R3
  AST_HIGH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flash_we_n_o) |-> (hi_run >= 16'(WPH_CYC))); // R4
  AST_CE_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_n_o |-> (!flash_ce_n_o && flash_oe_n_o)); // R5
  AST_DQ_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_n_o |-> flash_dq_oe_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!flash_dq_oe_o && flash_ce_n_o)); // R6
  AST_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hi_run >= 16'(BUSY_CYC))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o); // R9

endmodule

bind nor_prog_seq nor_prog_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WP_CYC   (WP_CYC),
  .WPH_CYC  (WPH_CYC),
  .BUSY_CYC (BUSY_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .flash_ce_n_o  (flash_ce_n_o),
  .flash_oe_n_o  (flash_oe_n_o),
  .flash_we_n_o  (flash_we_n_o),
  .flash_addr_o  (flash_addr_o),
  .flash_dq_o    (flash_dq_o),
  .flash_dq_oe_o (flash_dq_oe_o)
);

// File: tb/test_nor_prog_seq.sv
`timescale 1ns/1ps
module test_nor_prog_seq;

  localparam int AW = 20;
  localparam int DW = 32;
  localparam int EXP_WP   = 7;
  localparam int EXP_WPH  = 4;
  localparam int EXP_WC   = 11;
  localparam int EXP_BUSY = 18;
  localparam int EXP_TO   = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [DW-1:0] d_in = '0;
  logic          rdy = 1'b1;
  logic          busy, done, err, ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_dq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  nor_prog_seq i_nor_prog_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .addr_i        (a_in),
    .data_i        (d_in),
    .busy_o        (busy),
    .done_o        (done),
    .err_o         (err),
    .flash_ce_n_o  (ce_n),
    .flash_oe_n_o  (oe_n),
    .flash_we_n_o  (we_n),
    .flash_addr_o  (f_addr),
    .flash_dq_o    (f_dq),
    .flash_dq_oe_o (dq_oe),
    .flash_rdy_i   (rdy)
  );

  // bus monitor
  int            cyc = 0;
  logic          prev_we = 1'b1;
  int            pulses, lo_run, hi_run, last_fall, last_rise;
  int            done_cnt, done_cyc;
  logic          done_busy, done_err;
  int            v_stable, v_gap, v_strobe, v_oe;
  int            m_lo [2];
  logic [AW-1:0] m_addr [2];
  logic [DW-1:0] m_data [2];
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_dq;

  task automatic mon_clear();
    pulses = 0; lo_run = 0; hi_run = 0; last_fall = 0; last_rise = 0;
    done_cnt = 0; done_cyc = 0; done_busy = 0; done_err = 0;
    v_stable = 0; v_gap = 0; v_strobe = 0; v_oe = 0;
    m_lo[0] = 0; m_lo[1] = 0;
    m_addr[0] = '0; m_addr[1] = '0; m_data[0] = '0; m_data[1] = '0;
    cur_addr = '0; cur_dq = '0;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (!we_n) begin
        if (prev_we) begin
          if (pulses < 2) begin m_addr[pulses] = f_addr; m_data[pulses] = f_dq; end
          cur_addr = f_addr; cur_dq = f_dq;
          if (pulses > 0 && hi_run < EXP_WPH) v_gap++;
          if (pulses > 0 && (cyc - last_fall) < EXP_WC) v_gap++;
          last_fall = cyc; lo_run = 1;
        end else lo_run++;
        if (ce_n || !oe_n) v_strobe++;
        if (!dq_oe) v_oe++;
      end else begin
        if (!prev_we) begin
          if (pulses < 2) m_lo[pulses] = lo_run;
          pulses++; last_rise = cyc; hi_run = 1;
        end else hi_run++;
      end
      if (dq_oe && (f_addr !== cur_addr || f_dq !== cur_dq)) v_stable++;
      if (!busy && (dq_oe || !ce_n)) v_oe++;
      if (done) begin done_cnt++; done_cyc = cyc; done_busy = busy; done_err = err; end
    end
    prev_we = we_n;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input string what, input longint act,
                             input longint lo, input longint hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // one program operation; flash drops ready rd_dly cycles after the last
  // pulse and raises it rd_len cycles later (rd_len < 0: stays low until done)
  task automatic run_op(input logic [AW-1:0] pa, input logic [DW-1:0] pd,
                        input int rd_dly, input int rd_len, input bit poke_start);
    bit poked = 0;
    int k = 0;
    @(negedge clk);
    mon_clear();
    a_in = pa; d_in = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = ~pa; d_in = ~pd;
    check("R2", "busy after start", busy, 1);
    while (pulses < 2 && k < 200) begin
      if (poke_start && !poked && pulses == 1) begin
        start = 1'b1; a_in = pa ^ AW'(1); d_in = pd ^ DW'(1); poked = 1;
      end else start = 1'b0;
      @(negedge clk); k++;
    end
    start = 1'b0;
    k = 0;
    while (done_cnt == 0 && k < 10000) begin
      if (rd_dly >= 0 && k == rd_dly) rdy = 1'b0;
      if (rd_dly >= 0 && rd_len >= 0 && k == rd_dly + rd_len) rdy = 1'b1;
      @(negedge clk); k++;
    end
    rdy = 1'b1;
    check("R2", "write pulses", pulses, 2);
    check("R2", "cmd address", m_addr[0], 'h555);
    check("R2", "cmd data", m_data[0], 'hA0);
    check("R3", "first pulse width", m_lo[0], EXP_WP);
    check("R3", "second pulse width", m_lo[1], EXP_WP);
    check("R3", "bus stability faults", v_stable, 0);
    check("R4", "gap faults", v_gap, 0);
    check("R5", "strobe faults", v_strobe, 0);
    check("R6", "drive faults", v_oe, 0);
    check("R8", "done pulses", done_cnt, 1);
    check("R8", "busy at done", done_busy, 0);
  endtask

  task automatic t_reset();
    check("R1", "ce_n", ce_n, 1);
    check("R1", "we_n", we_n, 1);
    check("R1", "oe_n", oe_n, 1);
    check("R1", "dq_oe", dq_oe, 0);
    check("R1", "busy/done/err", {busy, done, err}, 0);
  endtask

  task automatic t_normal();
    run_op(20'hABCDE, 32'h1234_5678, 3, 1400, 0);
    check("R2", "program address", m_addr[1], 20'hABCDE);
    check("R2", "program data", m_data[1], 32'h1234_5678);
    check("R8", "error on success", done_err, 0);
    check_range("R8", "done after ready rise", done_cyc - last_rise, 1403 + 1, 1403 + 8);
  endtask

  task automatic t_ready_always();
    run_op(20'h00001, 32'hFFFF_0000, -1, -1, 0);
    check("R2", "program address", m_addr[1], 20'h00001);
    check_range("R7", "done delay with ready high", done_cyc - last_rise, EXP_BUSY + 1, EXP_BUSY + 8);
    check("R8", "error on success", done_err, 0);
  endtask

  task automatic t_timeout();
    run_op(20'h7FFFF, 32'hDEAD_BEEF, 0, -1, 0);
    check("R9", "error at done", done_err, 1);
    check_range("R9", "timeout delay", done_cyc - last_rise, EXP_BUSY + EXP_TO, EXP_BUSY + EXP_TO + 8);
    repeat (5) @(negedge clk);
    check("R9", "error held", err, 1);
    run_op(20'h00F0F, 32'h0BAD_F00D, 2, 50, 0);
    check("R9", "error cleared by new op", done_err, 0);
  endtask

  task automatic t_start_busy();
    run_op(20'h33333, 32'hCAFE_0001, 5, 100, 1);
    check("R10", "program address kept", m_addr[1], 20'h33333);
    check("R10", "program data kept", m_data[1], 32'hCAFE_0001);
    repeat (40) @(negedge clk);
    check("R10", "no extra pulses", pulses, 2);
    check("R10", "idle after op", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_ready_always();
    t_timeout();
    t_start_busy();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule